// File: doc/BRIEF.md
# Paged Switch Register Bridge

This block sits on a simple 32-bit host register bus and gives a processor access to a switch's internal register space, which is addressed by a page number and a register number. The host must first ask for access through a request bit in a control register. An external arbiter then grants it, and the grant can be read back. Once the grant is held, the host loads a 64-bit write value as two words and writes a command word. The command word names the page, the register and the direction, and sets a go bit. The bridge raises a level request toward the switch and holds the command fields steady until the switch answers with a one-cycle acknowledge. The go bit reads back as 1 for the whole transaction and clears by itself on that acknowledge.

For a read, the switch's 64-bit answer is latched into two read-data words at the moment the go bit clears. Byte, halfword, word and 48-bit accesses use only the low bits of these words. Separately, the bridge captures single-cycle event pulses from the switch into sticky bits, which software clears by writing 1. It drives one host interrupt line from them.

Top module: `swreg_bridge`

## Requirements
- R1: After reset every register reads 0, except the two input flags shown in the control word. The switch request, the arbiter request and the interrupt output are 0. Addresses not in the map read 0.
- R2: Control word at 0x40: bit 3 is the arbiter request and drives `arb_req`. Bit 1 is the interrupt enable. Bit 4 reads `arb_gnt` and bit 6 reads `sw_init_done`; both are read-only.
- R3: A write to the command word at 0x2C with bit 0 set and bit 2 clear is accepted when `arb_gnt` is 1 and no transaction is open. Its fields are page in bits 31:24, register in bits 23:16, and bit 1 set for a write or clear for a read. From the next cycle `sw_req` is 1 and carries those fields, with `sw_wdata` = {word at 0x30, word at 0x34}. Bit 0 of the command word then reads 1.
- R4: On the cycle after `sw_ack` is seen with a transaction open, `sw_req` and command bit 0 are 0. For a read, `sw_rdata` appears in the same cycle as high word at 0x38 and low word at 0x3C.
- R5: A command written while `arb_gnt` is 0 is ignored: `sw_req` stays 0 and command bit 0 stays 0.
- R6: A command written while a transaction is open is ignored: the page, register and direction on the switch port do not change.
- R7: Writing the command word with bit 2 set ends any open transaction. `sw_req` and command bit 0 are 0 the next cycle, bit 2 reads 0, and a later `sw_ack` changes nothing.
- R8: A write transaction and its acknowledge leave the read-data words unchanged.
- R9: Event bit i of `evt_pulse` sets bit i of the capture word at 0x44. The bit stays set until a host write to 0x44 with bit i = 1. Writing 0 to a bit leaves it set, and writing all ones clears every bit.
- R10: When a pulse and a clear hit the same capture bit in the same cycle, the bit ends up set.
- R11: `irq` equals the OR of all capture bits ANDed with control bit 1.
- R12: Host writes to the read-data words at 0x38 and 0x3C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | One-cycle access strobe |
| host_we | input | 1 | Write enable, qualified by host_sel |
| host_addr | input | 8 | Byte address of the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| arb_req | output | 1 | Access request to the arbiter |
| arb_gnt | input | 1 | Access grant from the arbiter |
| sw_init_done | input | 1 | Switch initialization finished |
| sw_req | output | 1 | Transaction open toward the switch |
| sw_write | output | 1 | 1 = write, 0 = read |
| sw_page | output | 8 | Page number |
| sw_regn | output | 8 | Register number within the page |
| sw_wdata | output | 64 | Write value |
| sw_ack | input | 1 | One-cycle completion from the switch |
| sw_rdata | input | 64 | Read value, valid with sw_ack |
| evt_pulse | input | 13 | Single-cycle event pulses from the switch |
| irq | output | 1 | Host interrupt |

## Verification
A stuck or wrongly set busy state shows at the ports within one cycle. It appears as `sw_req` staying high after an acknowledge, rising without a grant, or command bit 0 disagreeing with `sw_req`. The bench samples all of these in the cycle straight after each command and each acknowledge. A wrong read capture shows in the read words on that same cycle, because the low word is sampled together with the falling request. The capture bits are swept one at a time, so a lost or crossed event bit shows as the wrong word at 0x44 or a wrong `irq` level one cycle after the pulse.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

   // register offsets (byte addresses)
   localparam logic [7:0] OFF_CMD  = 8'h2C;
   localparam logic [7:0] OFF_WDH  = 8'h30;
   localparam logic [7:0] OFF_WDL  = 8'h34;
   localparam logic [7:0] OFF_RDH  = 8'h38;
   localparam logic [7:0] OFF_RDL  = 8'h3C;
   localparam logic [7:0] OFF_CTRL = 8'h40;
   localparam logic [7:0] OFF_EVT  = 8'h44;

   // command word fields
   localparam int CMD_GO_BIT    = 0;
   localparam int CMD_WR_BIT    = 1;
   localparam int CMD_ABORT_BIT = 2;
   localparam int CMD_REGN_LSB  = 16;
   localparam int CMD_PAGE_LSB  = 24;

   // control word fields
   localparam int CTL_IRQEN_BIT = 1;
   localparam int CTL_REQ_BIT   = 3;
   localparam int CTL_GNT_BIT   = 4;
   localparam int CTL_INIT_BIT  = 6;

endpackage

// File: rtl/swreg_cmd_fsm.sv
module swreg_cmd_fsm #(
   parameter int PAGE_W = 8,
   parameter int REGN_W = 8,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              abort,
   input  logic              gnt,
   input  logic [PAGE_W-1:0] page_in,
   input  logic [REGN_W-1:0] regn_in,
   input  logic              wr_in,
   input  logic              sw_ack,
   input  logic [DATA_W-1:0] sw_rdata,
   output logic              busy,
   output logic [PAGE_W-1:0] cur_page,
   output logic [REGN_W-1:0] cur_regn,
   output logic              cur_wr,
   output logic [DATA_W-1:0] rd_data
);

   logic accept;
   assign accept = launch && gnt && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_page <= '0;
         cur_regn <= '0;
         cur_wr   <= 1'b0;
         rd_data  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
      end else if (busy) begin
         if (sw_ack) begin
            busy <= 1'b0;
            if (!cur_wr) rd_data <= sw_rdata;
         end
      end else if (accept) begin
         busy     <= 1'b1;
         cur_page <= page_in;
         cur_regn <= regn_in;
         cur_wr   <= wr_in;
      end
   end

   // R5: a transaction only opens after a cycle with the grant present
   p_open_needs_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(gnt));

   // R4: an acknowledge closes the open transaction
   p_ack_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sw_ack && !abort) |=> !busy);

   // R6: fields hold while a transaction waits
   p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sw_ack && !abort) |=> (busy && $stable(cur_page) && $stable(cur_regn) && $stable(cur_wr)));

   // R7: abort always leaves the engine idle
   p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy);

   // R8: read words move only on a read acknowledge
   p_rd_only_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && sw_ack && !cur_wr) |=> $stable(rd_data));

endmodule

// File: rtl/swreg_evt_capture.sv
module swreg_evt_capture #(
   parameter int EVT_W   = 13,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_pulse,
   input  logic             clr_wr,
   input  logic [EVT_W-1:0] clr_mask,
   input  logic             irq_en,
   output logic [EVT_W-1:0] cap,
   output logic             irq
);

   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)            cap[i] <= 1'b0;
         else if (evt_pulse[i]) cap[i] <= 1'b1;
         else if (clr_wr && clr_mask[i]) cap[i] <= 1'b0;
      end
   end

   logic irq_next;
   assign irq_next = irq_en && (|cap);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_next;
      end
   end else begin : g_irq_comb
      assign irq = irq_next;

      // R11: no interrupt while disabled
      p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_en |-> !irq);
   end

   // R9, R10: every pulse is captured, whatever else happens that cycle
   p_pulse_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> ((cap & $past(evt_pulse)) == $past(evt_pulse)));

   // R9: without a clear write, captured bits never drop
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((cap & $past(cap)) == $past(cap)));

endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
   import swreg_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int WORD_W  = 32,
   parameter int PAGE_W  = 8,
   parameter int REGN_W  = 8,
   parameter int EVT_W   = 13,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_sel,
   input  logic                host_we,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic [WORD_W-1:0]   host_wdata,
   output logic [WORD_W-1:0]   host_rdata,
   output logic                arb_req,
   input  logic                arb_gnt,
   input  logic                sw_init_done,
   output logic                sw_req,
   output logic                sw_write,
   output logic [PAGE_W-1:0]   sw_page,
   output logic [REGN_W-1:0]   sw_regn,
   output logic [2*WORD_W-1:0] sw_wdata,
   input  logic                sw_ack,
   input  logic [2*WORD_W-1:0] sw_rdata,
   input  logic [EVT_W-1:0]    evt_pulse,
   output logic                irq
);

   localparam int DATA_W = 2 * WORD_W;

   if (WORD_W != 32) begin : g_bad_word
      $error("swreg_bridge: WORD_W must be 32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("swreg_bridge: ADDR_W must be at least 8");
   end
   if (PAGE_W < 1 || PAGE_W > 8 || REGN_W < 1 || REGN_W > 8) begin : g_bad_fields
      $error("swreg_bridge: page and register widths must be 1..8");
   end
   if (EVT_W < 1 || EVT_W > WORD_W) begin : g_bad_evt
      $error("swreg_bridge: EVT_W out of range");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return a == ADDR_W'(off);
   endfunction

   logic wr_cmd, wr_wdh, wr_wdl, wr_ctrl, wr_evt;
   assign wr_cmd  = host_sel && host_we && hit(host_addr, OFF_CMD);
   assign wr_wdh  = host_sel && host_we && hit(host_addr, OFF_WDH);
   assign wr_wdl  = host_sel && host_we && hit(host_addr, OFF_WDL);
   assign wr_ctrl = host_sel && host_we && hit(host_addr, OFF_CTRL);
   assign wr_evt  = host_sel && host_we && hit(host_addr, OFF_EVT);

   // write-data words and control bits
   logic [WORD_W-1:0] wd_hi, wd_lo;
   logic              req_q, irq_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wd_hi    <= '0;
         wd_lo    <= '0;
         req_q    <= 1'b0;
         irq_en_q <= 1'b0;
      end else begin
         if (wr_wdh) wd_hi <= host_wdata;
         if (wr_wdl) wd_lo <= host_wdata;
         if (wr_ctrl) begin
            req_q    <= host_wdata[CTL_REQ_BIT];
            irq_en_q <= host_wdata[CTL_IRQEN_BIT];
         end
      end
   end

   assign arb_req  = req_q;
   assign sw_wdata = {wd_hi, wd_lo};

   // command engine
   logic              busy;
   logic [DATA_W-1:0] rd_data;

   swreg_cmd_fsm #(
      .PAGE_W (PAGE_W),
      .REGN_W (REGN_W),
      .DATA_W (DATA_W)
   ) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (wr_cmd && host_wdata[CMD_GO_BIT] && !host_wdata[CMD_ABORT_BIT]),
      .abort    (wr_cmd && host_wdata[CMD_ABORT_BIT]),
      .gnt      (arb_gnt),
      .page_in  (host_wdata[CMD_PAGE_LSB +: PAGE_W]),
      .regn_in  (host_wdata[CMD_REGN_LSB +: REGN_W]),
      .wr_in    (host_wdata[CMD_WR_BIT]),
      .sw_ack   (sw_ack),
      .sw_rdata (sw_rdata),
      .busy     (busy),
      .cur_page (sw_page),
      .cur_regn (sw_regn),
      .cur_wr   (sw_write),
      .rd_data  (rd_data)
   );

   assign sw_req = busy;

   // event capture
   logic [EVT_W-1:0] cap;

   swreg_evt_capture #(
      .EVT_W   (EVT_W),
      .IRQ_REG (IRQ_REG)
   ) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .clr_wr    (wr_evt),
      .clr_mask  (host_wdata[EVT_W-1:0]),
      .irq_en    (irq_en_q),
      .cap       (cap),
      .irq       (irq)
   );

   // read mux
   always_comb begin
      host_rdata = '0;
      if (hit(host_addr, OFF_CMD)) begin
         host_rdata[CMD_PAGE_LSB +: PAGE_W] = sw_page;
         host_rdata[CMD_REGN_LSB +: REGN_W] = sw_regn;
         host_rdata[CMD_WR_BIT]             = sw_write;
         host_rdata[CMD_GO_BIT]             = busy;
      end else if (hit(host_addr, OFF_WDH)) begin
         host_rdata = wd_hi;
      end else if (hit(host_addr, OFF_WDL)) begin
         host_rdata = wd_lo;
      end else if (hit(host_addr, OFF_RDH)) begin
         host_rdata = rd_data[DATA_W-1:WORD_W];
      end else if (hit(host_addr, OFF_RDL)) begin
         host_rdata = rd_data[WORD_W-1:0];
      end else if (hit(host_addr, OFF_CTRL)) begin
         host_rdata[CTL_INIT_BIT]  = sw_init_done;
         host_rdata[CTL_GNT_BIT]   = arb_gnt;
         host_rdata[CTL_REQ_BIT]   = req_q;
         host_rdata[CTL_IRQEN_BIT] = irq_en_q;
      end else if (hit(host_addr, OFF_EVT)) begin
         host_rdata[EVT_W-1:0] = cap;
      end
   end

   // R2: the arbiter request follows the last control write
   p_req_tracks_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (arb_req == $past(host_wdata[CTL_REQ_BIT])));

   // R3: switch fields stay put while a request is pending
   p_port_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && !sw_ack && !wr_cmd) |=> (sw_req && $stable(sw_page) && $stable(sw_regn)));

endmodule

// File: tb/swreg_bridge_bench.sv
module swreg_bridge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_we = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        arb_req, arb_gnt = 1'b0, sw_init_done = 1'b0;
   logic        sw_req, sw_write;
   logic [7:0]  sw_page, sw_regn;
   logic [63:0] sw_wdata;
   logic        sw_ack = 1'b0;
   logic [63:0] sw_rdata = '0;
   logic [12:0] evt_pulse = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   swreg_bridge u_swreg_bridge (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .arb_req(arb_req), .arb_gnt(arb_gnt), .sw_init_done(sw_init_done),
      .sw_req(sw_req), .sw_write(sw_write), .sw_page(sw_page), .sw_regn(sw_regn),
      .sw_wdata(sw_wdata), .sw_ack(sw_ack), .sw_rdata(sw_rdata),
      .evt_pulse(evt_pulse), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   function automatic logic [63:0] swfun(input logic [7:0] p, input logic [7:0] r);
      return {p, r, p ^ 8'h5A, r + 8'h11, ~p, ~r, p + r, 8'hC3};
   endfunction

   logic [31:0] v;
   logic [63:0] exp_rd = '0;
   logic [31:0] seed = 32'h1234_5678;

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 8'h2C; a <= 8'h44; a += 4) begin
         rd(8'(a), v);
         chk($sformatf("R1 reg %h", a), 64'(v), 64'h0);
      end
      rd(8'h10, v); chk("R1 unmapped", 64'(v), 64'h0);
      chk("R1 outputs", {61'h0, sw_req, arb_req, irq}, 64'h0);

      // R5: command without grant
      wr(8'h2C, 32'h0102_0001);
      chk("R5 no req", 64'(sw_req), 64'h0);
      rd(8'h2C, v); chk("R5 go bit", 64'(v[0]), 64'h0);

      // R2: grant handshake
      wr(8'h40, 32'h0000_0008);
      chk("R2 arb_req", 64'(arb_req), 64'h1);
      repeat (3) @(negedge clk);
      arb_gnt = 1'b1; sw_init_done = 1'b1;
      rd(8'h40, v); chk("R2 ctrl", 64'(v), 64'h58);

      // R3, R4, R6, R8: command sweep
      for (int i = 0; i < 16; i++) begin
         logic [7:0]  pg, rg;
         logic        w;
         logic [31:0] hi, lo;
         seed = seed * 32'd1103515245 + 32'd12345;
         pg = seed[31:24]; rg = seed[15:8] ^ 8'(i);
         w  = i[0];
         hi = seed ^ 32'hA5A5_0000; lo = ~seed;
         wr(8'h30, hi);
         wr(8'h34, lo);
         wr(8'h2C, {pg, rg, 14'h0, w, 1'b1});
         chk($sformatf("R3 req %0d", i), 64'(sw_req), 64'h1);
         chk($sformatf("R3 fields %0d", i), {47'h0, w, pg, rg}, {47'h0, sw_write, sw_page, sw_regn});
         chk($sformatf("R3 wdata %0d", i), sw_wdata, {hi, lo});
         rd(8'h2C, v); chk($sformatf("R3 readback %0d", i), 64'(v), 64'({pg, rg, 14'h0, w, 1'b1}));
         if (i % 3 == 0) begin
            wr(8'h2C, {~pg, ~rg, 14'h0, ~w, 1'b1});
            chk($sformatf("R6 hold %0d", i), {47'h0, sw_write, sw_page, sw_regn}, {47'h0, w, pg, rg});
         end
         repeat (i % 4) begin
            @(negedge clk);
            chk($sformatf("R4 still open %0d", i), 64'(sw_req), 64'h1);
         end
         @(negedge clk);
         sw_ack = 1'b1; sw_rdata = swfun(pg, rg); host_addr = 8'h3C;
         if (!w) exp_rd = swfun(pg, rg);
         @(negedge clk);
         sw_ack = 1'b0;
         #1;
         chk($sformatf("R4 req low %0d", i), 64'(sw_req), 64'h0);
         chk($sformatf("R4 R8 rd low %0d", i), 64'(host_rdata), 64'(exp_rd[31:0]));
         rd(8'h38, v); chk($sformatf("R4 R8 rd high %0d", i), 64'(v), 64'(exp_rd[63:32]));
         rd(8'h2C, v); chk($sformatf("R4 go clear %0d", i), 64'(v[0]), 64'h0);
      end

      // R7: abort
      wr(8'h2C, 32'h3344_0001);
      chk("R7 open", 64'(sw_req), 64'h1);
      wr(8'h2C, 32'h0000_0004);
      chk("R7 req dropped", 64'(sw_req), 64'h0);
      rd(8'h2C, v); chk("R7 go and abort bits", 64'(v[2:0]), 64'h0);
      @(negedge clk);
      sw_ack = 1'b1; sw_rdata = 64'hDEAD_BEEF_0BAD_F00D;
      @(negedge clk);
      sw_ack = 1'b0;
      rd(8'h3C, v); chk("R7 late ack ignored", 64'(v), 64'(exp_rd[31:0]));

      // R12: read words are read-only
      wr(8'h3C, 32'hFFFF_FFFF);
      wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h3C, v); chk("R12 rdl", 64'(v), 64'(exp_rd[31:0]));
      rd(8'h38, v); chk("R12 rdh", 64'(v), 64'(exp_rd[63:32]));
      rd(8'h20, v); chk("R12 unmapped", 64'(v), 64'h0);

      // R9, R11: per-bit sweep
      for (int b = 0; b < 13; b++) begin
         wr(8'h40, 32'h0000_0008);
         @(negedge clk); evt_pulse = 13'(1 << b);
         @(negedge clk); evt_pulse = '0;
         rd(8'h44, v); chk($sformatf("R9 set %0d", b), 64'(v), 64'(1 << b));
         chk($sformatf("R11 disabled %0d", b), 64'(irq), 64'h0);
         wr(8'h40, 32'h0000_000A);
         chk($sformatf("R11 enabled %0d", b), 64'(irq), 64'h1);
         wr(8'h44, ~(32'(1 << b)));
         rd(8'h44, v); chk($sformatf("R9 zero keeps %0d", b), 64'(v), 64'(1 << b));
         wr(8'h44, 32'(1 << b));
         rd(8'h44, v); chk($sformatf("R9 clear %0d", b), 64'(v), 64'h0);
         chk($sformatf("R11 idle %0d", b), 64'(irq), 64'h0);
      end

      // R10: pulse beats clear
      @(negedge clk); evt_pulse = 13'h020;
      @(negedge clk); evt_pulse = '0;
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = 8'h44; host_wdata = 32'h0000_0020;
      evt_pulse = 13'h020;
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0; evt_pulse = '0;
      rd(8'h44, v); chk("R10 pulse wins", 64'(v), 64'h20);

      // R9, R11: several bits, clear all
      @(negedge clk); evt_pulse = 13'h1A81;
      @(negedge clk); evt_pulse = '0;
      rd(8'h44, v); chk("R9 multi", 64'(v), 64'h1AA1);
      chk("R11 multi", 64'(irq), 64'h1);
      wr(8'h44, 32'hFFFF_FFFF);
      rd(8'h44, v); chk("R9 clear all", 64'(v), 64'h0);
      chk("R11 after clear", 64'(irq), 64'h0);

      // R2: release
      wr(8'h40, 32'h0000_0002);
      chk("R2 release", 64'(arb_req), 64'h0);
      arb_gnt = 1'b0;
      rd(8'h40, v); chk("R2 ctrl after release", 64'(v), 64'h42);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule